// File: doc/BRIEF.md
# Serial Wire Debug Bit Shift Engine

This block is the host-side bit mover of a two-wire debug link. It owns the serial clock output and the bidirectional data line, and on command it either shifts a burst of 1 to 32 bits out to the target or clocks a burst of 1 to 32 bits in from it. Each command carries its direction, its length written as the bit count less one, and, for an outgoing burst, the bits to send. Every command ends with exactly one response: the collected bits for an incoming burst, or a plain completion word for an outgoing one.

A higher layer builds packets from these bursts. It sends the request header, reads the acknowledge, reads or writes the data phase and inserts turnaround cycles by issuing read or write bursts of the right length. The engine sets the data line's direction for each burst. Between bursts it parks the clock low and, after any outgoing burst, drives the data line high.

Top module: `swd_bit_engine`

## Requirements
- R1: After reset the serial clock is low, the data line is driven as an output at level 1, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A command whose length field holds n produces exactly n+1 rising edges of the serial clock, so n = 0 moves one bit.
- R3: A write burst drives the data line as an output (`swdio_oe` = 1) and presents `cmd_wdata` least significant bit first. Each bit is set while the clock is low and does not change across the following rising edge.
- R4: When a write burst ends, the data line is left driven at 1 and the clock low, and one response is issued with `rsp_data` equal to zero.
- R5: A read burst releases the data line (`swdio_oe` = 0) before its first rising edge and keeps it released to the end. The bit sampled during the k-th high clock phase lands in `rsp_data` bit k-1, and every bit above the burst length is zero.
- R6: With `USE_SEP_DIN` = 1 the read bits come from `swdi_i` and `swdio_i` has no effect. With `USE_SEP_DIN` = 0 they come from `swdio_i`.
- R7: Every high phase of the serial clock lasts exactly `HALF_CYCLES` system clock cycles, and so does every low phase inside a burst.
- R8: `cmd_ready` is 1 only when the engine is idle with no response pending. A response stays valid, with its data unchanged, until `rsp_ready` is 1, and no command is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_is_read | input | 1 | 1 = read burst, 0 = write burst |
| cmd_len_m1 | input | CNT_W | Bit count less one |
| cmd_wdata | input | DATA_W | Bits to send, LSB first |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Read bits right-aligned, or zero after a write |
| swclk_o | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input value |
| swdi_i | input | 1 | Separate data input pin |

## Verification
A command is accepted at the clock edge where both `cmd_valid` and `cmd_ready` are high. For a burst of n+1 bits the response appears about 2·(n+1)·`HALF_CYCLES` cycles later, and it can stay pending for any number of cycles after that. The checks therefore never count a fixed delay. The driver queues the expected word and waits until the monitor has popped it. Bit-level results are taken on the serial clock's own rising edges, and line levels and handshake signals are sampled on falling system clock edges, one half period after the registers that drive them have settled.

// File: rtl/swd_bit_engine.sv
module swd_bit_engine #(
  parameter int DATA_W      = 32,
  parameter int HALF_CYCLES = 2,
  parameter bit USE_SEP_DIN = 1'b0,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_read,
  input  logic [CNT_W-1:0]  cmd_len_m1,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i,
  input  logic              swdi_i
);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_RESP} state_t;

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYCLES - 1);

  state_t            state;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  bits_q;
  logic [CNT_W-1:0]  len_q;
  logic [DATA_W-1:0] shreg;

  wire din       = USE_SEP_DIN ? swdi_i : swdio_i;
  wire phase_end = (div_q == '0);
  wire [DATA_W-1:0] rd_next = {din, shreg[DATA_W-1:1]};

  assign cmd_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div_q    <= '0;
      bits_q   <= '0;
      len_q    <= '0;
      shreg    <= '0;
      rsp_data <= '0;
      swclk_o  <= 1'b0;
      swdio_o  <= 1'b1;
      swdio_oe <= 1'b1;
    end else begin
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          div_q  <= DIV_LAST;
          bits_q <= cmd_len_m1;
          len_q  <= cmd_len_m1;
          if (cmd_is_read) begin
            swdio_oe <= 1'b0;
            state    <= S_RLO;
          end else begin
            swdio_oe <= 1'b1;
            swdio_o  <= cmd_wdata[0];
            shreg    <= cmd_wdata >> 1;
            state    <= S_WLO;
          end
        end
        S_WLO: begin
          if (phase_end) begin
            swclk_o <= 1'b1;
            div_q   <= DIV_LAST;
            state   <= S_WHI;
          end else div_q <= div_q - 1'b1;
        end
        S_WHI: begin
          if (phase_end) begin
            swclk_o <= 1'b0;
            div_q   <= DIV_LAST;
            if (bits_q == '0) begin
              swdio_o  <= 1'b1;
              rsp_data <= '0;
              state    <= S_RESP;
            end else begin
              swdio_o <= shreg[0];
              shreg   <= shreg >> 1;
              bits_q  <= bits_q - 1'b1;
              state   <= S_WLO;
            end
          end else div_q <= div_q - 1'b1;
        end
        S_RLO: begin
          if (phase_end) begin
            swclk_o <= 1'b1;
            div_q   <= DIV_LAST;
            state   <= S_RHI;
          end else div_q <= div_q - 1'b1;
        end
        S_RHI: begin
          if (phase_end) begin
            swclk_o <= 1'b0;
            div_q   <= DIV_LAST;
            shreg   <= rd_next;
            if (bits_q == '0) begin
              rsp_data <= rd_next >> (CNT_W'(DATA_W - 1) - len_q);
              state    <= S_RESP;
            end else begin
              bits_q <= bits_q - 1'b1;
              state  <= S_RLO;
            end
          end else div_q <= div_q - 1'b1;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swd_bit_engine_chk.sv
module swd_bit_engine_chk #(
  parameter int DATA_W      = 32,
  parameter int HALF_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              swclk_o,
  input logic              swdio_o,
  input logic              swdio_oe
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (swclk_o) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R8
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  // R3
  data_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swclk_o) && swdio_oe |-> $stable(swdio_o) && $past(swdio_oe));

  // R4
  write_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && swdio_oe |-> swdio_o && !swclk_o);

  // R5
  release_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swdio_oe) |-> !swclk_o);

  // R7
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swclk_o) |-> hi_cnt == 16'(HALF_CYCLES));

endmodule

bind swd_bit_engine swd_bit_engine_chk #(.DATA_W(DATA_W), .HALF_CYCLES(HALF_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .swclk_o(swclk_o),
  .swdio_o(swdio_o), .swdio_oe(swdio_oe)
);

// File: tb/test_swd_bit_engine.sv
module test_swd_bit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_is_read = 1'b0;
  logic [4:0]  cmd_len_m1 = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        swclk_o, swdio_o, swdio_oe;
  logic        swdio_i, swdi_i;

  int checks = 0;
  int fails = 0;
  logic [31:0] expq[$];
  logic [31:0] tgt = '0;
  int tidx = 0;
  int edge_cnt = 0;
  int dir_bad = 0;
  int hi_run = 0;
  int hi_bad = 0;
  bit cur_read = 1'b0;
  logic [31:0] wcap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_bit_engine #(.DATA_W(32), .HALF_CYCLES(HALF), .USE_SEP_DIN(1'b1)) i_swd_bit_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_is_read(cmd_is_read), .cmd_len_m1(cmd_len_m1), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
    .swdio_i(swdio_i), .swdi_i(swdi_i)
  );

  // target model: dedicated pin carries the pattern, the shared pin its inverse (R6)
  assign swdi_i  = (tidx < 32) ? tgt[tidx] : 1'b0;
  assign swdio_i = ~swdi_i;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge swclk_o) tidx++;

  always @(posedge swclk_o) begin
    if (edge_cnt < 32) wcap[edge_cnt] = swdio_o;
    if (swdio_oe == cur_read) dir_bad++;
    edge_cnt++;
  end

  always @(negedge clk) begin
    if (swclk_o) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != HALF) hi_bad++;
      hi_run = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) check(1'b0, "R8 unexpected response", rsp_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(rsp_data === e, cur_read ? "R5/R6 read data" : "R4 write completion", rsp_data, e);
      end
    end
  end

  task automatic run_op(bit rd, int lm1, logic [31:0] d);
    logic [31:0] mask;
    mask = (lm1 == 31) ? 32'hFFFF_FFFF : ((32'd1 << (lm1 + 1)) - 1);
    cur_read = rd; edge_cnt = 0; dir_bad = 0; tidx = 0; tgt = d; wcap = '0;
    expq.push_back(rd ? (d & mask) : 32'h0);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = rd; cmd_len_m1 = 5'(lm1); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    check(edge_cnt == lm1 + 1, "R2 rising edge count", 32'(edge_cnt), 32'(lm1 + 1));
    check(dir_bad == 0, rd ? "R5 line released" : "R3 line driven", 32'(dir_bad), 32'h0);
    if (!rd) begin
      check((wcap & mask) == (d & mask), "R3 bits LSB first", wcap & mask, d & mask);
      check(swdio_o === 1'b1 && swclk_o === 1'b0 && swdio_oe === 1'b1,
            "R4 idle high clock low", {29'h0, swdio_oe, swclk_o, swdio_o}, 32'h5);
    end else begin
      check(swdio_oe === 1'b0 && swclk_o === 1'b0, "R5 clock low after read",
            {30'h0, swdio_oe, swclk_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(swclk_o === 1'b0 && swdio_o === 1'b1 && swdio_oe === 1'b1 &&
          cmd_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset state",
          {27'h0, rsp_valid, cmd_ready, swdio_oe, swdio_o, swclk_o}, 32'hE);

    run_op(1'b0, 7, 32'h0000_00A5);
    run_op(1'b0, 31, 32'hDEAD_BEEF);
    run_op(1'b0, 0, 32'h1);
    run_op(1'b0, 0, 32'h0);
    run_op(1'b1, 7, 32'h0000_003C);
    run_op(1'b1, 31, 32'h1234_5678);
    run_op(1'b1, 0, 32'hFFFF_FFFF);
    run_op(1'b1, 15, 32'hFFFF_FFFF);
    run_op(1'b1, 4, 32'hA5A5_A5B6);

    // R8: response held while not taken, no command accepted meanwhile
    rsp_ready = 1'b0;
    cur_read = 1'b0; edge_cnt = 0; dir_bad = 0;
    expq.push_back(32'h0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = 1'b0; cmd_len_m1 = 5'd3; cmd_wdata = 32'h9;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = 1'b1; cmd_len_m1 = 5'd2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && cmd_ready === 1'b0, "R8 response held, not ready",
            {30'h0, rsp_valid, cmd_ready}, 32'h2);
    end
    check(edge_cnt == 4, "R8 no new burst while pending", 32'(edge_cnt), 32'd4);
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    check(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R8 idle after response taken",
          {30'h0, rsp_valid, cmd_ready}, 32'h1);

    // R7
    check(hi_bad == 0, "R7 high phase length", 32'(hi_bad), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule